// File: doc/BRIEF.md
# Auto-Reload Timer with Selectable Count Source

This block is a 16-bit up-counter made of two 8-bit byte lanes, with a matching 16-bit reload value. Software sets it up through a small byte-wide register port and then starts it with a run bit. Each count step comes from one of three sources: every system clock cycle, one cycle in twelve, or every eighth rising edge of an external oscillator pin. That pin is brought into the system clock domain through a two-stage synchronizer first.

There are two operating modes. In joined mode the two lanes form one 16-bit counter, which reloads when it wraps past all ones. In split mode each lane counts and reloads on its own. Each lane has a sticky overflow flag. The interrupt output is the enabled OR of the flags, and the low-lane flag has its own enable.

The register port is a plain control interface. It has no valid/ready handshake, because no data stream passes through the block. A write takes effect at the clock edge where `reg_wr` is high. Reads are combinational from `reg_addr`.

Top module: `reload_timer`

## Requirements
- R1: After reset, every register reads zero and `irq` is low.
- R2: Register offsets are 0 control, 1 count low byte, 2 count high byte, 3 reload low byte and 4 reload high byte.
  - Control bit 0 is run, bit 1 is split mode, bit 2 is the low-flag interrupt enable and bit 3 is the interrupt enable.
  - Bits 5:4 select the source: 0 is the system clock, 1 is the system clock divided by 12, 2 is the external pin divided by 8, and 3 means no count steps.
  - Bit 6 is the low flag and bit 7 is the high flag.
- R3: With run at 0, the count does not change.
- R4: With source 0 and run at 1, the count advances by one on every clock edge after the edge that wrote run.
- R5: With source 1, the count advances exactly once in any 12 consecutive clock edges.
- R6: With source 2, the count advances once for every 8 rising edges seen on `ext_osc`, within 3 clocks of the eighth edge.
- R7: In joined mode, a step taken from 0xFFFF loads the 16-bit reload value and sets the high flag.
- R8: In split mode, each lane steps on its own.
  - A lane at 0xFF loads its own reload byte instead of wrapping.
  - The high lane sets the high flag.
- R9: In both modes, any step taken while the low byte is 0xFF sets the low flag.
- R10: The flags are sticky.
  - Writing 0 to a flag bit clears that flag.
  - Writing 1 leaves it as it is.
  - A flag set by a step in the same cycle wins over a clear.
- R11: `irq` = interrupt enable AND (high flag OR (low-flag enable AND low flag)).
- R12: A write to a count byte takes priority over a step in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_osc | input | 1 | External oscillator, asynchronous to `clk` |
| reg_addr | input | 3 | Register offset |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr`, combinational |
| irq | output | 1 | Interrupt request |

## Verification
A register write takes one edge, and the read that follows is sampled at the next falling edge. The run bit is registered, so the edge that writes run=1 does not step the counter, but the edge that writes run=0 still does. That makes a run window of n idle cycles worth exactly n+1 steps, and the bench's reference model applies that many steps.

Flags and `irq` follow the edge of the step that set them. For the divided source, the bench uses a 120-edge window, which holds exactly 10 steps whatever the prescaler phase. For the external source, the bench waits at least 6 clocks after the last pin edge, which covers the 3-clock synchronizer delay.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  typedef enum logic [1:0] {
    SRC_SYS   = 2'd0,
    SRC_DIV12 = 2'd1,
    SRC_EXT8  = 2'd2,
    SRC_OFF   = 2'd3
  } src_e;

  typedef struct packed {
    src_e src;
    logic irq_en;
    logic lo_irq_en;
    logic split;
    logic run;
  } ctrl_t;

  localparam logic [2:0] A_CTRL = 3'd0;
  localparam logic [2:0] A_CLO  = 3'd1;
  localparam logic [2:0] A_CHI  = 3'd2;
  localparam logic [2:0] A_RLO  = 3'd3;
  localparam logic [2:0] A_RHI  = 3'd4;
endpackage

// File: rtl/tmr_tick_gen.sv
module tmr_tick_gen
  import tmr_pkg::*;
#(
  parameter int DIV_SLOW    = 12,
  parameter int EXT_DIV     = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ext_osc,
  input  src_e src,
  output logic tick
);
  localparam int PW = $clog2(DIV_SLOW);
  localparam int EW = $clog2(EXT_DIV);
  localparam logic [PW-1:0] PRE_LAST = PW'(DIV_SLOW - 1);
  localparam logic [EW-1:0] EXT_LAST = EW'(EXT_DIV - 1);

  logic [PW-1:0] pre;
  logic          slow_tick;
  logic [SYNC_STAGES:0] sh;
  logic          rise;
  logic [EW-1:0] ecnt;
  logic          ext_tick;

  assign slow_tick = (pre == PRE_LAST);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) pre <= '0;
    else        pre <= slow_tick ? '0 : pre + 1'b1;

  // Two-stage synchronizer plus one history flop for edge detection.
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) sh <= '0;
    else        sh <= {sh[SYNC_STAGES-1:0], ext_osc};

  assign rise     = sh[SYNC_STAGES-1] & ~sh[SYNC_STAGES];
  assign ext_tick = rise && (ecnt == EXT_LAST);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)    ecnt <= '0;
    else if (rise) ecnt <= ext_tick ? '0 : ecnt + 1'b1;

  always_comb
    case (src)
      SRC_SYS:   tick = 1'b1;
      SRC_DIV12: tick = slow_tick;
      SRC_EXT8:  tick = ext_tick;
      default:   tick = 1'b0;
    endcase

  assert_slow_gap_R5: assert property (@(posedge clk) disable iff (!rst_n)
    slow_tick |=> !slow_tick);
  assert_ext_gap_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ext_tick |=> !ext_tick);
endmodule

// File: rtl/tmr_count_core.sv
module tmr_count_core #(
  parameter int HALF = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            step,
  input  logic            split,
  input  logic [2*HALF-1:0] rld,
  input  logic            wr_lo,
  input  logic            wr_hi,
  input  logic [HALF-1:0] wdata,
  output logic [2*HALF-1:0] cnt,
  output logic            ovf_lo,
  output logic            ovf_hi
);
  localparam logic [HALF-1:0] TOP = '1;

  logic [HALF-1:0] lo, hi, lo_nx, hi_nx;
  logic lo_max, hi_max, full;

  assign lo_max = (lo == TOP);
  assign hi_max = (hi == TOP);
  assign full   = lo_max && hi_max;

  always_comb begin
    lo_nx = lo;
    hi_nx = hi;
    if (step) begin
      if (split) begin
        lo_nx = lo_max ? rld[HALF-1:0] : lo + 1'b1;
        hi_nx = hi_max ? rld[2*HALF-1:HALF] : hi + 1'b1;
      end else if (full) begin
        lo_nx = rld[HALF-1:0];
        hi_nx = rld[2*HALF-1:HALF];
      end else begin
        lo_nx = lo + 1'b1;
        hi_nx = lo_max ? hi + 1'b1 : hi;
      end
    end
  end

  assign ovf_lo = step && lo_max;
  assign ovf_hi = step && (split ? hi_max : full);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      lo <= '0;
      hi <= '0;
    end else begin
      lo <= wr_lo ? wdata : lo_nx;
      hi <= wr_hi ? wdata : hi_nx;
    end

  assign cnt = {hi, lo};

  assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!step && !wr_lo && !wr_hi) |=> $stable(cnt));
  assert_reload_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !split && cnt == '1 && !wr_lo && !wr_hi) |=> cnt == $past(rld));
  assert_write_wins_R12: assert property (@(posedge clk) disable iff (!rst_n)
    wr_lo |=> cnt[HALF-1:0] == $past(wdata));
endmodule

// File: rtl/reload_timer.sv
module reload_timer
  import tmr_pkg::*;
#(
  parameter int DIV_SLOW = 12,
  parameter int EXT_DIV  = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ext_osc,
  input  logic [2:0] reg_addr,
  input  logic       reg_wr,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  output logic       irq
);
  localparam int HALF = 8;

  ctrl_t            ctrl;
  logic             flag_lo, flag_hi;
  logic [2*HALF-1:0] rld, cnt;
  logic             tick, ovf_lo, ovf_hi;
  logic             wr_ctrl;

  assign wr_ctrl = reg_wr && (reg_addr == A_CTRL);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      ctrl <= '0;
      rld  <= '0;
    end else if (reg_wr) begin
      case (reg_addr)
        A_CTRL:  ctrl <= ctrl_t'(reg_wdata[5:0]);
        A_RLO:   rld[HALF-1:0] <= reg_wdata;
        A_RHI:   rld[2*HALF-1:HALF] <= reg_wdata;
        default: ;
      endcase
    end

  // A set from an overflow wins over a software clear in the same cycle.
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      flag_lo <= 1'b0;
      flag_hi <= 1'b0;
    end else begin
      flag_lo <= ovf_lo | (flag_lo & ~(wr_ctrl & ~reg_wdata[6]));
      flag_hi <= ovf_hi | (flag_hi & ~(wr_ctrl & ~reg_wdata[7]));
    end

  tmr_tick_gen #(.DIV_SLOW(DIV_SLOW), .EXT_DIV(EXT_DIV), .SYNC_STAGES(2)) u_tick (
    .clk(clk), .rst_n(rst_n), .ext_osc(ext_osc), .src(ctrl.src), .tick(tick)
  );

  tmr_count_core #(.HALF(HALF)) u_core (
    .clk(clk), .rst_n(rst_n), .step(tick && ctrl.run), .split(ctrl.split),
    .rld(rld), .wr_lo(reg_wr && reg_addr == A_CLO),
    .wr_hi(reg_wr && reg_addr == A_CHI), .wdata(reg_wdata),
    .cnt(cnt), .ovf_lo(ovf_lo), .ovf_hi(ovf_hi)
  );

  always_comb
    case (reg_addr)
      A_CTRL:  reg_rdata = {flag_hi, flag_lo, ctrl};
      A_CLO:   reg_rdata = cnt[HALF-1:0];
      A_CHI:   reg_rdata = cnt[2*HALF-1:HALF];
      A_RLO:   reg_rdata = rld[HALF-1:0];
      A_RHI:   reg_rdata = rld[2*HALF-1:HALF];
      default: reg_rdata = '0;
    endcase

  assign irq = ctrl.irq_en & (flag_hi | (ctrl.lo_irq_en & flag_lo));

  assert_irq_src_R11: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (flag_hi || flag_lo));
  assert_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_hi && !(wr_ctrl && !reg_wdata[7])) |=> flag_hi);
  assert_flag_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_hi) |-> $past(ctrl.run));
endmodule

// File: tb/tb_reload_timer.sv
module tb_reload_timer;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ext_osc = 1'b0;
  logic [2:0] reg_addr = '0;
  logic reg_wr = 1'b0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic irq;
  int checks = 0;
  int fails = 0;

  always #5 clk = ~clk;

  reload_timer dut (
    .clk(clk), .rst_n(rst_n), .ext_osc(ext_osc), .reg_addr(reg_addr),
    .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Called at a falling edge; uses exactly one rising edge.
  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] v);
    reg_addr = a;
    #1;
    v = reg_rdata;
  endtask

  task automatic rd_cnt(output logic [15:0] v);
    logic [7:0] l, h;
    rd(3'd1, l);
    rd(3'd2, h);
    v = {h, l};
  endtask

  function automatic logic [17:0] mstep(input logic [17:0] s, input logic sp,
                                        input logic [15:0] r);
    logic fh = s[17];
    logic fl = s[16];
    logic [7:0] h = s[15:8];
    logic [7:0] l = s[7:0];
    if (l == 8'hFF) fl = 1'b1;
    if (sp) begin
      if (h == 8'hFF) begin h = r[15:8]; fh = 1'b1; end
      else h = h + 8'd1;
      l = (l == 8'hFF) ? r[7:0] : l + 8'd1;
    end else if ({h, l} == 16'hFFFF) begin
      {h, l} = r; fh = 1'b1;
    end else begin
      {h, l} = {h, l} + 16'd1;
    end
    return {fh, fl, h, l};
  endfunction

  function automatic logic exp_irq(input logic ie, input logic le,
                                   input logic fh, input logic fl);
    return ie & (fh | (le & fl));
  endfunction

  // One run of n idle cycles, started from a stopped timer with clear flags.
  task automatic run_case(input string req, input logic sp, input logic ie,
                          input logic le, input logic [15:0] r,
                          input logic [15:0] start, input int n);
    logic [17:0] s;
    logic [15:0] c;
    logic [7:0] cr;
    wr(3'd0, 8'h00);
    wr(3'd3, r[7:0]);
    wr(3'd4, r[15:8]);
    wr(3'd1, start[7:0]);
    wr(3'd2, start[15:8]);
    wr(3'd0, {2'b11, 2'b00, ie, le, sp, 1'b1});
    repeat (n) @(negedge clk);
    wr(3'd0, {2'b11, 2'b00, ie, le, sp, 1'b0});
    s = {2'b00, start};
    for (int i = 0; i < n + 1; i++) s = mstep(s, sp, r);
    rd_cnt(c);
    chk({req, " count"}, c, s[15:0]);
    rd(3'd0, cr);
    chk({req, " flags"}, {14'd0, cr[7:6]}, {14'd0, s[17:16]});
    chk({req, " irq"}, {15'd0, irq}, {15'd0, exp_irq(ie, le, s[17], s[16])});
  endtask

  initial begin
    #2_000_000;
    fails++;
    checks++;
    $display("FAIL watchdog timeout");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic [15:0] c;
    logic [7:0] v;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset state
    for (int a = 0; a < 5; a++) begin
      rd(3'(a), v);
      chk("R1 reset reg", {8'd0, v}, 16'd0);
    end
    chk("R1 reset irq", {15'd0, irq}, 16'd0);

    // R2/R4: system clock source, joined mode, register map
    run_case("R4 sysclk", 1'b0, 1'b0, 1'b0, 16'h0000, 16'h0010, 9);
    rd(3'd3, v);
    chk("R2 reload low readback", {8'd0, v}, 16'h0000);

    // R3: stopped timer holds
    wr(3'd1, 8'h55);
    repeat (20) @(negedge clk);
    rd(3'd1, v);
    chk("R3 hold while stopped", {8'd0, v}, 16'h0055);

    // R7 + R9 + R11: wrap past all ones
    run_case("R7 reload", 1'b0, 1'b1, 1'b0, 16'h1234, 16'hFFFE, 1);
    // R8: split lanes
    run_case("R8 split", 1'b1, 1'b1, 1'b1, 16'h0580, 16'hFFFE, 1);
    // R9 + R11: low flag only, low-flag enable off then on
    run_case("R9 low flag gated", 1'b0, 1'b1, 1'b0, 16'h0000, 16'h00FE, 3);
    run_case("R11 low flag enabled", 1'b0, 1'b1, 1'b1, 16'h0000, 16'h00FE, 3);

    // R10: sticky flags, write-1 keeps, write-0 clears one flag
    run_case("R10 set both", 1'b0, 1'b0, 1'b0, 16'hAB00, 16'hFFFF, 0);
    wr(3'd0, 8'hC0);
    rd(3'd0, v);
    chk("R10 write one keeps", {14'd0, v[7:6]}, 16'd3);
    wr(3'd0, 8'h40);
    rd(3'd0, v);
    chk("R10 clear high only", {14'd0, v[7:6]}, 16'd1);
    wr(3'd0, 8'h08);
    chk("R11 irq off with low flag cleared", {15'd0, irq}, 16'd0);

    // R12: a count write beats a step in the same cycle
    wr(3'd1, 8'h00);
    wr(3'd2, 8'h00);
    wr(3'd0, 8'hC1);
    repeat (5) @(negedge clk);
    wr(3'd1, 8'h40);
    rd(3'd1, v);
    chk("R12 write priority", {8'd0, v}, 16'h0040);
    repeat (3) @(negedge clk);
    rd(3'd1, v);
    chk("R12 count resumes", {8'd0, v}, 16'h0043);
    wr(3'd0, 8'h00);

    // R5: divide-by-12 over a 120-edge window
    wr(3'd1, 8'h00);
    wr(3'd2, 8'h00);
    wr(3'd0, 8'h11);
    repeat (119) @(negedge clk);
    wr(3'd0, 8'h10);
    rd_cnt(c);
    chk("R5 div12", c, 16'd10);

    // R6: external source divided by 8
    wr(3'd1, 8'h00);
    wr(3'd0, 8'h21);
    for (int i = 0; i < 16; i++) begin
      ext_osc = 1'b1;
      repeat (5) @(negedge clk);
      ext_osc = 1'b0;
      repeat (5) @(negedge clk);
    end
    repeat (6) @(negedge clk);
    wr(3'd0, 8'h20);
    rd_cnt(c);
    chk("R6 ext div8", c, 16'd2);

    // Source 3 gives no steps (R2)
    wr(3'd1, 8'h07);
    wr(3'd0, 8'h31);
    repeat (30) @(negedge clk);
    wr(3'd0, 8'h30);
    rd(3'd1, v);
    chk("R2 source off", {8'd0, v}, 16'h0007);

    // Constrained random runs (R4 R7 R8 R9 R11)
    for (int k = 0; k < 40; k++) begin
      logic [15:0] r, st;
      logic sp, ie, le;
      int n;
      sp = 1'($urandom % 2);
      ie = 1'($urandom % 2);
      le = 1'($urandom % 2);
      r  = 16'($urandom);
      st[7:0]  = 8'hF0 + 8'($urandom % 16);
      st[15:8] = ($urandom % 2) ? 8'hFF - 8'($urandom % 4) : 8'($urandom);
      n = int'($urandom % 40);
      run_case("R8 random", sp, ie, le, r, st, n);
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule